// File: doc/BRIEF.md
# Four-Beat Pipelined Read Port

This block is the read side of a dual-port burst memory whose storage array is shared with a separate write port. A caller lowers an active-low select together with an address on a command beat. A fixed number of beats later, the block returns the four words of the addressed row, lowest word first, on four consecutive beats. A valid flag marks exactly those beats. The block works on a single beat clock that runs at twice the command rate. Each rising edge of that clock is one data beat, and beats alternate between command (positive-half) beats and negative-half beats, starting with a command beat on the first edge after reset.

Two latencies are provided. The normal one is two and a half command cycles, which is five beats. A fallback of one command cycle, which is two beats, is chosen with a static mode input. A request that arrives one command cycle after an accepted one is dropped. Requests spaced two command cycles apart stream data with no idle beat between them. Instead of tristating, the block drives an output-enable flag. That flag drops only at a command beat, after the negative-half beat that follows the last word.

Top module: `burst4_read_port`

## Requirements
- R1: While reset is asserted, and on the first sample after it, q_valid, q_oe and q_data are all zero.
- R2: Edges are numbered from 0, starting with the first clock edge after reset is released. Even-numbered edges are command beats and odd-numbered edges are half beats. A low rd_sel_n is taken as a request only on a command beat. On a half beat it has no effect on any output.
- R3: With fast_mode low, word 0 of the row for a request accepted at edge e appears at edge e+5.
- R4: With fast_mode high, word 0 of the row for a request accepted at edge e appears at edge e+2.
- R5: The array row is 4×18 bits, and word k occupies bits [18k+17:18k]. The words are output in the order k = 0, 1, 2, 3 on four consecutive edges.
- R6: A request on the command beat directly after an accepted request (edge e+2) is ignored. The next command beat (edge e+4) accepts again.
- R7: Requests accepted every four edges produce valid data on every beat, with no gap between bursts, in both modes.
- R8: q_valid is high on exactly the four beats of each burst. q_oe is high whenever q_valid is high. After a burst, q_oe stays high through a half beat and falls at the next command beat. In normal mode it is high for one extra beat after the last word. In fallback mode it falls on the beat after the last word.
- R9: q_data is zero on every beat where q_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; each rising edge is one data beat |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_n | input | 1 | Active-low read request, sampled on command beats |
| rd_addr | input | ADDR_W | Row address of the request |
| fast_mode | input | 1 | 1 selects the one-cycle fallback latency; must be static |
| arr_raddr | output | ADDR_W | Row address presented to the shared array |
| arr_rdata | input | WORD_W*NWORDS | Row returned combinationally by the array |
| q_data | output | WORD_W | Read data word |
| q_valid | output | 1 | High on beats carrying read data |
| q_oe | output | 1 | Output-enable flag standing in for bus drive |

## Verification
The bench goes after four corner cases. The first is a request held low over several command beats. Only every other request may be taken, so a design that accepts the second one would start an overlapping burst and corrupt the word sequence. The second is a stream of requests every two command cycles in both modes. A design with an off-by-one latency, or one that relaunches a token already issued in fallback mode, would show a gap, a duplicated burst or shifted words. The third is a request offered only on half beats, which a design that ignores beat phase would wrongly serve. The fourth is the tail of each burst. There, an output enable that drops on the wrong beat, or stale data left on the bus after the last word, shows up as a mismatch in the beat-by-beat comparison.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    typedef enum logic {PH_CMD = 1'b0, PH_HALF = 1'b1} beat_ph_e;

    localparam int LAT_NORM_BEATS = 5;
    localparam int LAT_FAST_BEATS = 2;
endpackage

// File: rtl/rdp_accept.sv
module rdp_accept
    import rdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_sel_n,
    output logic cmd_o,
    output logic accept_o
);
    typedef struct packed {
        beat_ph_e ph;
        logic     blk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cmd_o    = (st_q.ph == PH_CMD);
        accept_o = cmd_o && !rd_sel_n && !st_q.blk;
        st_d.ph  = cmd_o ? PH_HALF : PH_CMD;
        if (cmd_o) st_d.blk = accept_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_CMD, blk: 1'b0};
        else        st_q <= st_d;
    end

    AST_CMD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o |=> !cmd_o); // R2
    AST_B2B_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> ##1 !accept_o); // R6
endmodule

// File: rtl/rdp_pipe.sv
module rdp_pipe
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_addr
);
    localparam int NSTG     = LAT_NORM_BEATS;
    localparam int TAP_NORM = LAT_NORM_BEATS - 1;
    localparam int TAP_FAST = LAT_FAST_BEATS - 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] adr;
    } tok_t;

    tok_t [NSTG-1:0] stg_d, stg_q;
    logic [NSTG-1:0] vld_vec;

    always_comb begin
        stg_d[0] = '{vld: accept, adr: addr};
        for (int i = 1; i < NSTG; i++) begin
            stg_d[i] = stg_q[i-1];
            if (fast_mode && (i == TAP_FAST + 1)) stg_d[i].vld = 1'b0;
        end
        launch      = fast_mode ? stg_q[TAP_FAST].vld : stg_q[TAP_NORM].vld;
        launch_addr = fast_mode ? stg_q[TAP_FAST].adr : stg_q[TAP_NORM].adr;
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
        assign vld_vec[g] = stg_q[g].vld;
    end

    AST_TWO_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_vec) <= 2); // R7
endmodule

// File: rtl/rdp_burst.sv
module rdp_burst #(
    parameter int WORD_W = 18,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd,
    input  logic                     launch,
    input  logic [WORD_W*NWORDS-1:0] arr_rdata,
    output logic [WORD_W-1:0]        q_data,
    output logic                     q_valid,
    output logic                     q_oe
);
    localparam int ROW_W = WORD_W * NWORDS;
    localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              oe;
        logic [IW-1:0]     idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        if (launch) begin
            st_d.row   = arr_rdata;
            st_d.data  = arr_rdata[WORD_W-1:0];
            st_d.valid = 1'b1;
            st_d.idx   = (NWORDS > 1) ? IW'(1) : '0;
        end else if (st_q.idx != '0) begin
            st_d.data  = st_q.row[st_q.idx*WORD_W +: WORD_W];
            st_d.valid = 1'b1;
            st_d.idx   = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
        end
        st_d.oe = st_d.valid || (st_q.oe && !cmd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_data  = st_q.data;
    assign q_valid = st_q.valid;
    assign q_oe    = st_q.oe;

    AST_NO_MIDBURST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (st_q.idx == '0 || st_q.idx == LAST)); // R7
    AST_OE_COVERS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> q_oe); // R8
    AST_OE_DROPS_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_oe) |-> $past(cmd)); // R8
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q_data == '0)); // R9
endmodule

// File: rtl/burst4_read_port.sv
module burst4_read_port #(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 18,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_sel_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     fast_mode,
    output logic [ADDR_W-1:0]        arr_raddr,
    input  logic [WORD_W*NWORDS-1:0] arr_rdata,
    output logic [WORD_W-1:0]        q_data,
    output logic                     q_valid,
    output logic                     q_oe
);
    logic cmd, accept, launch;

    rdp_accept u_accept (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .cmd_o    (cmd),
        .accept_o (accept)
    );

    rdp_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_mode   (fast_mode),
        .accept      (accept),
        .addr        (rd_addr),
        .launch      (launch),
        .launch_addr (arr_raddr)
    );

    rdp_burst #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .launch    (launch),
        .arr_rdata (arr_rdata),
        .q_data    (q_data),
        .q_valid   (q_valid),
        .q_oe      (q_oe)
    );
endmodule

// File: tb/tb_burst4_read_port.sv
module tb_burst4_read_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int WW   = 18;
    localparam int NW   = 4;
    localparam int RW   = WW * NW;
    localparam int MAXB = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          fast_mode = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] arr_raddr;
    logic [RW-1:0] arr_rdata;
    logic [WW-1:0] q_data;
    logic          q_valid, q_oe;

    int n_cmp = 0;
    int n_bad = 0;

    logic          req_a [MAXB];
    logic [AW-1:0] adr_a [MAXB];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [RW-1:0] rowf(input logic [AW-1:0] a);
        return {a[17:0] ^ 18'h3c3c3, a[17:0] + 18'd7, ~a[17:0], a[17:0] ^ 18'h00a5a};
    endfunction

    assign arr_rdata = rowf(arr_raddr);

    burst4_read_port #(.ADDR_W(AW), .WORD_W(WW), .NWORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .fast_mode(fast_mode), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
        .q_data(q_data), .q_valid(q_valid), .q_oe(q_oe)
    );

    task automatic clear_sched();
        for (int i = 0; i < MAXB; i++) begin
            req_a[i] = 1'b0;
            adr_a[i] = '0;
        end
    endtask

    task automatic run_sched(input string tag, input logic fast);
        logic          ev [MAXB];
        logic          eo [MAXB];
        logic [WW-1:0] ed [MAXB];
        logic [RW-1:0] r;
        int last_acc;
        int lat;
        lat = fast ? 5 - 3 : 5;
        last_acc = -100;
        for (int i = 0; i < MAXB; i++) begin
            ev[i] = 1'b0; eo[i] = 1'b0; ed[i] = '0;
        end
        for (int e = 0; e < MAXB; e++) begin
            if ((e % 2 == 0) && req_a[e] && (last_acc != e - 2)) begin
                last_acc = e;
                r = rowf(adr_a[e]);
                for (int k = 0; k < NW; k++) begin
                    if (e + lat + k < MAXB) begin
                        ev[e+lat+k] = 1'b1;
                        ed[e+lat+k] = r[k*WW +: WW];
                    end
                end
            end
        end
        for (int e = 0; e < MAXB; e++)
            eo[e] = ev[e] || (e > 0 && eo[e-1] && (e % 2 == 1));

        @(negedge clk);
        rst_n = 1'b0; fast_mode = fast; rd_sel_n = 1'b1; rd_addr = '0;
        repeat (2) @(negedge clk);
        n_cmp++;
        if (q_valid !== 1'b0 || q_oe !== 1'b0 || q_data !== '0) begin
            n_bad++;
            $display("FAIL R1 %s in reset: valid=%b oe=%b data=%h expected 0 0 0",
                     tag, q_valid, q_oe, q_data);
        end
        rst_n = 1'b1;
        for (int e = 0; e < MAXB; e++) begin
            rd_sel_n = !req_a[e];
            rd_addr  = adr_a[e];
            @(negedge clk);
            n_cmp++;
            if (q_valid !== ev[e] || q_oe !== eo[e] || q_data !== ed[e]) begin
                n_bad++;
                $display("FAIL %s edge %0d: valid=%b oe=%b data=%h expected valid=%b oe=%b data=%h",
                         tag, e, q_valid, q_oe, q_data, ev[e], eo[e], ed[e]);
            end
        end
        rd_sel_n = 1'b1;
    endtask

    task automatic t_single_normal();
        clear_sched();
        req_a[0] = 1'b1; adr_a[0] = 20'h12345;
        run_sched("R3 R5 R8 R9 normal single", 1'b0);
    endtask

    task automatic t_single_fast();
        clear_sched();
        req_a[2] = 1'b1; adr_a[2] = 20'h0beef;
        run_sched("R4 R5 R8 fast single", 1'b1);
    endtask

    task automatic t_back_to_back();
        clear_sched();
        for (int e = 0; e <= 10; e++) begin
            req_a[e] = 1'b1; adr_a[e] = AW'(20'h00100 + e);
        end
        run_sched("R6 held request", 1'b0);
    endtask

    task automatic t_stream(input logic fast);
        clear_sched();
        for (int e = 0; e <= 12; e += 4) begin
            req_a[e] = 1'b1; adr_a[e] = AW'(20'h0a000 + 3 * e);
        end
        run_sched(fast ? "R7 fast stream" : "R7 normal stream", fast);
    endtask

    task automatic t_half_beat_ignored();
        clear_sched();
        req_a[1] = 1'b1; adr_a[1] = 20'h55555;
        req_a[3] = 1'b1; adr_a[3] = 20'h66666;
        req_a[6] = 1'b1; adr_a[6] = 20'h77777;
        run_sched("R2 half-beat request", 1'b0);
    endtask

    task automatic t_release();
        clear_sched();
        req_a[4] = 1'b1; adr_a[4] = 20'hfffff;
        run_sched("R8 R9 release", 1'b0);
        clear_sched();
        req_a[4] = 1'b1; adr_a[4] = 20'h00000;
        run_sched("R8 R9 fast release", 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_single_normal();
        t_single_fast();
        t_back_to_back();
        t_stream(1'b0);
        t_stream(1'b1);
        t_half_beat_ignored();
        t_release();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule